// File: doc/BRIEF.md
# Machine/User Trap and CSR Unit

This unit keeps the control and status registers that a small two-privilege core needs to handle exceptions: a status word that holds a four-deep stack of privilege/interrupt-enable frames, the exception PC, the trap cause and a scratch word for the handler's own use. When the pipeline flags an exception, the unit records the faulting PC and the cause code, pushes a machine-mode frame onto the status stack and, one cycle later, tells fetch where to go. The target depends on the privilege the trap came from. An exception-return request pops the stack and sends fetch to whatever the exception PC holds at that moment, so a handler can move the resume point, for example past a system call.

CSR instructions are served in the cycle they are presented. A read returns the current value on a combinational path. A swap returns the old value and stores the new one. A plain write stores without returning data. Writes are refused in user mode and lose to a trap or a return in the same cycle.

The redirect logic is a four-state machine: `RD_IDLE` (no redirect), `RD_TRAP_USER` (drive the user-mode vector), `RD_TRAP_MACH` (drive the machine-mode vector) and `RD_RETURN` (drive the exception PC). From any state the machine goes to `RD_TRAP_USER` or `RD_TRAP_MACH` on a trap, according to the privilege at that moment. Failing a trap, it goes to `RD_RETURN` on a return request. Otherwise it goes to `RD_IDLE`. Each redirect state therefore lasts exactly one cycle unless a new request arrives.

Top module: `trap_csr_unit`

## Requirements
- R1: After reset the status word reads 0x006 (level 0 machine, interrupts off), scratch, exception PC and cause read 0, `cur_priv` is 3, `int_en` is 0 and `redirect_valid` is 0.
- R2: A trap stores `trap_pc` into the exception PC and `trap_cause` into the cause register. Cause 8 stands for an environment call and 2 for an illegal instruction.
- R3: Status level n occupies bits 3n+2:3n (privilege in 3n+2:3n+1, enable in 3n, user = 0, machine = 3). A trap shifts bits 8:0 up by three and writes level 0 as machine with enable 0. Bits 31:12 are kept.
- R4: The cycle after a trap, `redirect_valid` is 1 for one cycle. `redirect_pc` is 0x100 if the level-0 privilege was user and 0x1C0 otherwise.
- R5: A return request shifts bits 11:3 of the status word down by three and refills level 3 with user mode and enable 1. Bits 31:12 are kept.
- R6: The cycle after a return request, `redirect_valid` is 1 and `redirect_pc` equals the exception PC as it stood at the request, including any value that software wrote earlier.
- R7: `csr_op` 0 is a read that returns the addressed register in the same cycle. The addresses are status 0x300, scratch 0x340, exception PC 0x341 and cause 0x342. An unmapped address reads 0 and ignores writes.
- R8: `csr_op` 2 (swap) returns the old value and stores `csr_wdata`. `csr_op` 1 (write) stores `csr_wdata` and returns 0.
- R9: A CSR write or swap in the same cycle as a trap or a return request is dropped. The trap or return takes effect alone.
- R10: A CSR write or swap issued while the level-0 privilege is user (0) changes no register. Reads still work.
- R11: When a trap and a return request arrive together, the trap wins. The stack is pushed, not popped, and the redirect goes to the trap vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_valid | input | 1 | Exception reported by the pipeline |
| trap_cause | input | 32 | Cause code of the exception |
| trap_pc | input | 32 | PC of the faulting instruction |
| eret_valid | input | 1 | Exception-return request |
| csr_valid | input | 1 | CSR access present this cycle |
| csr_op | input | 2 | 0 read, 1 write, 2 swap |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 32 | Data for write or swap |
| csr_rdata | output | 32 | Read or swap result, same cycle |
| redirect_valid | output | 1 | Fetch redirect strobe |
| redirect_pc | output | 32 | Fetch redirect target |
| cur_priv | output | 2 | Current privilege (level 0) |
| int_en | output | 1 | Current interrupt enable (level 0) |

## Verification
The hardest state to reach is a status stack whose upper levels hold a mix of frames. Only traps and returns move the stack, and any write that might shape it is refused once the core drops to user mode. The stimulus first writes a crafted status word while still in machine mode to enter user mode. It then interleaves traps taken from user and machine mode with returns, so that nested pushes, a refilled level 3 and preserved upper bits all become visible through status reads. Collisions are driven in single cycles: a trap with a write, a return with a write, and a trap with a return.

// File: rtl/trap_csr_pkg.sv
package trap_csr_pkg;
    // CSR access kinds
    localparam logic [1:0] CSR_READ  = 2'd0;
    localparam logic [1:0] CSR_WRITE = 2'd1;
    localparam logic [1:0] CSR_SWAP  = 2'd2;

    // privilege encodings
    localparam logic [1:0] PRIV_USER = 2'd0;
    localparam logic [1:0] PRIV_MACH = 2'd3;

    // one stack frame: {priv[1:0], enable}
    localparam int         FRAME_W      = 3;
    localparam logic [2:0] FRAME_TRAP   = {PRIV_MACH, 1'b0};
    localparam logic [2:0] FRAME_REFILL = {PRIV_USER, 1'b1};

    // CSR address map
    localparam logic [11:0] ADDR_STATUS  = 12'h300;
    localparam logic [11:0] ADDR_SCRATCH = 12'h340;
    localparam logic [11:0] ADDR_EPC     = 12'h341;
    localparam logic [11:0] ADDR_CAUSE   = 12'h342;

    // cause codes recorded by software-visible convention
    localparam int CAUSE_ILLEGAL = 2;
    localparam int CAUSE_ECALL   = 8;

    typedef enum logic [1:0] {
        RD_IDLE      = 2'd0,
        RD_TRAP_USER = 2'd1,
        RD_TRAP_MACH = 2'd2,
        RD_RETURN    = 2'd3
    } redir_e;
endpackage

// File: rtl/trap_csr_stack.sv
module trap_csr_stack
    import trap_csr_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int LEVELS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic            pop,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_data,
    output logic [XLEN-1:0] status,
    output logic [1:0]      priv,
    output logic            ie
);
    localparam int STACK_W = FRAME_W * LEVELS;
    localparam logic [XLEN-1:0] RESET_VAL = {{(XLEN-FRAME_W){1'b0}}, FRAME_TRAP};

    logic [XLEN-1:0] status_q, status_d;
    logic [STACK_W-1:0] stack_q;

    assign stack_q = status_q[STACK_W-1:0];

    always_comb begin
        status_d = status_q;
        if (push) begin
            status_d[STACK_W-1:0] = {stack_q[STACK_W-FRAME_W-1:0], FRAME_TRAP};
        end else if (pop) begin
            status_d[STACK_W-1:0] = {FRAME_REFILL, stack_q[STACK_W-1:FRAME_W]};
        end else if (wr_en) begin
            status_d = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= RESET_VAL;
        else        status_q <= status_d;
    end

    assign status = status_q;
    assign priv   = status_q[2:1];
    assign ie     = status_q[0];
endmodule

// File: rtl/trap_csr_regs.sv
module trap_csr_regs
    import trap_csr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture,
    input  logic [XLEN-1:0] cap_pc,
    input  logic [XLEN-1:0] cap_cause,
    input  logic            wr_scratch,
    input  logic            wr_epc,
    input  logic            wr_cause,
    input  logic [XLEN-1:0] wr_data,
    output logic [XLEN-1:0] scratch,
    output logic [XLEN-1:0] epc,
    output logic [XLEN-1:0] cause
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scratch <= '0;
            epc     <= '0;
            cause   <= '0;
        end else begin
            if (wr_scratch) scratch <= wr_data;
            if (capture) begin
                epc   <= cap_pc;
                cause <= cap_cause;
            end else begin
                if (wr_epc)   epc   <= wr_data;
                if (wr_cause) cause <= wr_data;
            end
        end
    end
endmodule

// File: rtl/trap_csr_fsm.sv
module trap_csr_fsm
    import trap_csr_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] USER_VEC = 32'h100,
    parameter logic [XLEN-1:0] MACH_VEC = 32'h1C0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trap_req,
    input  logic            ret_req,
    input  logic            from_user,
    input  logic [XLEN-1:0] epc,
    output logic            redirect_valid,
    output logic [XLEN-1:0] redirect_pc
);
    redir_e state_q, state_d;

    always_comb begin
        if (trap_req)     state_d = from_user ? RD_TRAP_USER : RD_TRAP_MACH;
        else if (ret_req) state_d = RD_RETURN;
        else              state_d = RD_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            RD_IDLE: begin
                redirect_valid = 1'b0;
                redirect_pc    = '0;
            end
            RD_TRAP_USER: begin
                redirect_valid = 1'b1;
                redirect_pc    = USER_VEC;
            end
            RD_TRAP_MACH: begin
                redirect_valid = 1'b1;
                redirect_pc    = MACH_VEC;
            end
            RD_RETURN: begin
                redirect_valid = 1'b1;
                redirect_pc    = epc;
            end
            default: begin
                redirect_valid = 1'b0;
                redirect_pc    = '0;
            end
        endcase
    end
endmodule

// File: rtl/trap_csr_unit.sv
module trap_csr_unit
    import trap_csr_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              ADDR_W   = 12,
    parameter int              LEVELS   = 4,
    parameter logic [XLEN-1:0] USER_VEC = 32'h100,
    parameter logic [XLEN-1:0] MACH_VEC = 32'h1C0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_valid,
    input  logic [XLEN-1:0]   trap_cause,
    input  logic [XLEN-1:0]   trap_pc,
    input  logic              eret_valid,
    input  logic              csr_valid,
    input  logic [1:0]        csr_op,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic [XLEN-1:0]   csr_wdata,
    output logic [XLEN-1:0]   csr_rdata,
    output logic              redirect_valid,
    output logic [XLEN-1:0]   redirect_pc,
    output logic [1:0]        cur_priv,
    output logic              int_en
);
    logic [XLEN-1:0] status_q, scratch_q, epc_q, cause_q;
    logic            do_write, do_pop;
    logic            hit_status, hit_scratch, hit_epc, hit_cause;

    assign hit_status  = (csr_addr == ADDR_W'(ADDR_STATUS));
    assign hit_scratch = (csr_addr == ADDR_W'(ADDR_SCRATCH));
    assign hit_epc     = (csr_addr == ADDR_W'(ADDR_EPC));
    assign hit_cause   = (csr_addr == ADDR_W'(ADDR_CAUSE));

    // writes lose to traps/returns and are refused in user mode
    assign do_write = csr_valid && (csr_op == CSR_WRITE || csr_op == CSR_SWAP)
                      && (cur_priv != PRIV_USER) && !trap_valid && !eret_valid;
    assign do_pop   = eret_valid && !trap_valid;

    trap_csr_stack #(.XLEN(XLEN), .LEVELS(LEVELS)) u_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (trap_valid),
        .pop     (do_pop),
        .wr_en   (do_write && hit_status),
        .wr_data (csr_wdata),
        .status  (status_q),
        .priv    (cur_priv),
        .ie      (int_en)
    );

    trap_csr_regs #(.XLEN(XLEN)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (trap_valid),
        .cap_pc     (trap_pc),
        .cap_cause  (trap_cause),
        .wr_scratch (do_write && hit_scratch),
        .wr_epc     (do_write && hit_epc),
        .wr_cause   (do_write && hit_cause),
        .wr_data    (csr_wdata),
        .scratch    (scratch_q),
        .epc        (epc_q),
        .cause      (cause_q)
    );

    trap_csr_fsm #(.XLEN(XLEN), .USER_VEC(USER_VEC), .MACH_VEC(MACH_VEC)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .trap_req       (trap_valid),
        .ret_req        (do_pop),
        .from_user      (cur_priv == PRIV_USER),
        .epc            (epc_q),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc)
    );

    always_comb begin
        csr_rdata = '0;
        if (csr_valid && csr_op != CSR_WRITE) begin
            if (hit_status)  csr_rdata = status_q;
            if (hit_scratch) csr_rdata = scratch_q;
            if (hit_epc)     csr_rdata = epc_q;
            if (hit_cause)   csr_rdata = cause_q;
        end
    end
endmodule

// File: rtl/trap_csr_chk.sv
module trap_csr_chk
    import trap_csr_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              LEVELS   = 4,
    parameter logic [XLEN-1:0] USER_VEC = 32'h100
) (
    input logic            clk,
    input logic            rst_n,
    input logic            trap_valid,
    input logic [XLEN-1:0] trap_cause,
    input logic [XLEN-1:0] trap_pc,
    input logic            eret_valid,
    input logic            csr_valid,
    input logic [1:0]      csr_op,
    input logic            redirect_valid,
    input logic [XLEN-1:0] redirect_pc,
    input logic [1:0]      cur_priv,
    input logic [XLEN-1:0] status_q,
    input logic [XLEN-1:0] scratch_q,
    input logic [XLEN-1:0] epc_q,
    input logic [XLEN-1:0] cause_q
);
    localparam int SW = FRAME_W * LEVELS;

    assert_trap_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |=> (epc_q == $past(trap_pc)) && (cause_q == $past(trap_cause)));

    assert_trap_push_R3: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |=> status_q[SW-1:0] == {$past(status_q[SW-FRAME_W-1:0]), FRAME_TRAP});

    assert_user_vector_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && cur_priv == PRIV_USER) |=> redirect_valid && redirect_pc == USER_VEC);

    assert_quiet_redirect_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_valid && !eret_valid) |=> !redirect_valid);

    assert_ret_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (eret_valid && !trap_valid) |=> status_q[SW-1:0] == {FRAME_REFILL, $past(status_q[SW-1:FRAME_W])});

    assert_ret_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (eret_valid && !trap_valid) |=> redirect_valid && redirect_pc == $past(epc_q));

    assert_user_write_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_valid && csr_op != CSR_READ && cur_priv == PRIV_USER && !trap_valid && !eret_valid)
        |=> $stable(scratch_q) && $stable(status_q) && $stable(epc_q) && $stable(cause_q));
endmodule

bind trap_csr_unit trap_csr_chk #(.XLEN(XLEN), .LEVELS(LEVELS), .USER_VEC(USER_VEC)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .trap_valid     (trap_valid),
    .trap_cause     (trap_cause),
    .trap_pc        (trap_pc),
    .eret_valid     (eret_valid),
    .csr_valid      (csr_valid),
    .csr_op         (csr_op),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .cur_priv       (cur_priv),
    .status_q       (status_q),
    .scratch_q      (scratch_q),
    .epc_q          (epc_q),
    .cause_q        (cause_q)
);

// File: tb/sim_trap_csr_unit.sv
module sim_trap_csr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_valid = 1'b0;
    logic [31:0] trap_cause = '0;
    logic [31:0] trap_pc = '0;
    logic        eret_valid = 1'b0;
    logic        csr_valid = 1'b0;
    logic [1:0]  csr_op = '0;
    logic [11:0] csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        redirect_valid;
    logic [31:0] redirect_pc;
    logic [1:0]  cur_priv;
    logic        int_en;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    trap_csr_unit u0 (
        .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_cause(trap_cause),
        .trap_pc(trap_pc), .eret_valid(eret_valid), .csr_valid(csr_valid), .csr_op(csr_op),
        .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .cur_priv(cur_priv), .int_en(int_en)
    );

    localparam logic [11:0] A_ST = 12'h300, A_SC = 12'h340, A_EP = 12'h341, A_CA = 12'h342;

    typedef struct packed {
        logic [1:0]  op;
        logic [11:0] addr;
        logic [31:0] wdata;
        logic [31:0] expect_rd;
    } vec_t;

    // machine-mode access sequence (R7, R8)
    localparam vec_t TBL [0:10] = '{
        '{2'd1, A_SC, 32'hA5A5_0001, 32'h0},
        '{2'd0, A_SC, 32'h0,         32'hA5A5_0001},
        '{2'd2, A_SC, 32'h0000_1234, 32'hA5A5_0001},
        '{2'd0, A_SC, 32'h0,         32'h0000_1234},
        '{2'd1, A_EP, 32'h0000_2000, 32'h0},
        '{2'd0, A_EP, 32'h0,         32'h0000_2000},
        '{2'd2, A_CA, 32'h0000_0002, 32'h0},
        '{2'd0, A_CA, 32'h0,         32'h0000_0002},
        '{2'd1, 12'h7C0, 32'hFFFF_FFFF, 32'h0},
        '{2'd0, 12'h7C0, 32'h0,      32'h0},
        '{2'd0, A_ST, 32'h0,         32'h0000_0006}
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, got, exp);
        end
    endtask

    // one cycle of stimulus; rdata sampled before the edge, inputs released after it
    task automatic cycle(input bit trp, input bit ret, input bit cv, input logic [1:0] op,
                         input logic [11:0] a, input logic [31:0] d,
                         input logic [31:0] cause, input logic [31:0] pc,
                         output logic [31:0] rd);
        @(negedge clk);
        trap_valid = trp; eret_valid = ret; csr_valid = cv; csr_op = op;
        csr_addr = a; csr_wdata = d; trap_cause = cause; trap_pc = pc;
        #1 rd = csr_rdata;
        @(posedge clk);
        #1;
        trap_valid = 1'b0; eret_valid = 1'b0; csr_valid = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] r;
        cycle(0, 0, 1, 2'd0, a, '0, '0, '0, r);
        chk(req, r, exp);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        logic [31:0] r;
        cycle(0, 0, 1, 2'd1, a, d, '0, '0, r);
    endtask

    // after a trap/return cycle: redirect visible now, gone after the next edge
    task automatic redir_chk(input string req, input logic [31:0] exp_pc);
        chk(req, {31'b0, redirect_valid}, 32'd1);
        chk(req, redirect_pc, exp_pc);
        @(posedge clk);
        #1 chk(req, {31'b0, redirect_valid}, 32'd0);
    endtask

    initial begin
        logic [31:0] r;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        chk("R1 redirect", {31'b0, redirect_valid}, 32'd0);
        chk("R1 priv", {30'b0, cur_priv}, 32'd3);
        chk("R1 int_en", {31'b0, int_en}, 32'd0);
        rd_chk("R1 status", A_ST, 32'h6);
        rd_chk("R1 scratch", A_SC, 32'h0);
        rd_chk("R1 epc", A_EP, 32'h0);
        rd_chk("R1 cause", A_CA, 32'h0);

        // table walk: R7 and R8
        foreach (TBL[i]) begin
            cycle(0, 0, 1, TBL[i].op, TBL[i].addr, TBL[i].wdata, '0, '0, r);
            chk("R7/R8 table", r, TBL[i].expect_rd);
        end

        // drop to user: level0 user+ie, level1 machine
        wr(A_ST, 32'h31);
        chk("R10 user priv", {30'b0, cur_priv}, 32'd0);
        chk("R10 user ie", {31'b0, int_en}, 32'd1);
        cycle(0, 0, 1, 2'd2, A_SC, 32'hDEAD, '0, '0, r);
        chk("R10 swap in user still reads", r, 32'h1234);
        wr(A_SC, 32'hBEEF);
        wr(A_ST, 32'h6);
        rd_chk("R10 scratch unchanged", A_SC, 32'h1234);
        rd_chk("R10 status unchanged", A_ST, 32'h31);

        // environment call from user
        cycle(1, 0, 0, 2'd0, '0, '0, 32'd8, 32'h400, r);
        redir_chk("R4 user vector", 32'h100);
        rd_chk("R2 epc", A_EP, 32'h400);
        rd_chk("R2 cause ecall", A_CA, 32'd8);
        rd_chk("R3 push", A_ST, 32'h18E);
        chk("R3 priv machine", {30'b0, cur_priv}, 32'd3);

        // handler moves resume point, then returns
        wr(A_EP, 32'h404);
        cycle(0, 1, 0, 2'd0, '0, '0, '0, '0, r);
        redir_chk("R6 return target", 32'h404);
        rd_chk("R5 pop", A_ST, 32'h231);
        chk("R5 priv user", {30'b0, cur_priv}, 32'd0);

        // illegal instruction from user, then nested trap from machine
        cycle(1, 0, 0, 2'd0, '0, '0, 32'd2, 32'h500, r);
        redir_chk("R4 user vector 2", 32'h100);
        rd_chk("R2 cause illegal", A_CA, 32'd2);
        cycle(1, 0, 0, 2'd0, '0, '0, 32'd2, 32'h104, r);
        redir_chk("R4 machine vector", 32'h1C0);
        rd_chk("R3 nested push", A_ST, 32'hC76);

        // R9 trap with concurrent epc write
        cycle(1, 0, 1, 2'd1, A_EP, 32'hBEEF, 32'd8, 32'h600, r);
        redir_chk("R9 trap wins", 32'h1C0);
        rd_chk("R9 epc from trap", A_EP, 32'h600);
        rd_chk("R9 status push", A_ST, 32'h3B6);
        // R9 return with concurrent scratch swap
        cycle(0, 1, 1, 2'd2, A_SC, 32'h7777, '0, '0, r);
        redir_chk("R9 return wins", 32'h600);
        rd_chk("R9 scratch unchanged", A_SC, 32'h1234);
        rd_chk("R9 status pop", A_ST, 32'h276);

        // R11 trap and return together
        cycle(1, 1, 0, 2'd0, '0, '0, 32'd2, 32'h700, r);
        redir_chk("R11 trap over return", 32'h1C0);
        rd_chk("R11 pushed", A_ST, 32'h3B6);

        // R3/R5 upper bits preserved
        wr(A_ST, 32'hA000_0006);
        cycle(1, 0, 0, 2'd0, '0, '0, 32'd2, 32'h800, r);
        redir_chk("R3 vector", 32'h1C0);
        rd_chk("R3 upper kept", A_ST, 32'hA000_0036);
        cycle(0, 1, 0, 2'd0, '0, '0, '0, '0, r);
        redir_chk("R6 return", 32'h800);
        rd_chk("R5 upper kept", A_ST, 32'hA000_0206);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule